// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block sits beside a sampling converter core and decides which of its power domains are energised. A level-sensitive, active-low shutdown request takes the converter out of service. A separate depth-select level, captured on the clock edge that first sees the request, picks one of two resting states. In the shallow state the digital logic and the reference stay on and only the analog bias is cut. In the deep state every domain is off. When the request is withdrawn, the block counts a wake-up window whose length depends on the depth that was entered. Only after that window does it report ready again.

Conversion-start falling edges are filtered here. An edge is forwarded to the core as a one-cycle pulse only while the converter is fully awake. Edges seen during a resting state or during a wake-up window are dropped, not stored. A one-hot status word reports the current state. Both wake-up lengths are clock-cycle parameters; the defaults match 200 ns and 10 ms at a 250 MHz clock.

Top module: `conv_power_seq`

## Requirements
- R1: While reset is asserted and afterwards, the block is in the waking state with all domains on. It runs a wake-up window of the deep length (SLEEP_WAKE_CYC cycles counted from reset release) before it first becomes ready.
- R2: When `shdn_n` is sampled low in the ready state, the next state is the shallow rest if `depth_shallow` is high at that same edge, and the deep rest if it is low.
- R3: Domain enables by state: ready and waking drive all three enables high. The shallow rest drives `logic_en` and `ref_en` high and `bias_en` low. The deep rest drives all three low.
- R4: Changes of `depth_shallow` while resting have no effect. The state and the enables stay unchanged, and the following wake-up window has the length of the depth that was entered.
- R5: When `shdn_n` is sampled high in a resting state, the block enters waking on that edge. It stays waking for exactly NAP_WAKE_CYC (shallow) or SLEEP_WAKE_CYC (deep) cycles, then becomes ready. `ready` is high only in the ready state.
- R6: When `shdn_n` is sampled low while waking, the wake-up is abandoned. The block rests at the depth that `depth_shallow` selects at that edge.
- R7: A falling edge on `cnv_start_n` means high at one sampling edge and low at the next. When the second edge finds the block ready and `shdn_n` high, it produces exactly one cycle of `cnv_go`, visible after that edge. A level held low gives no further pulse.
- R8: Falling edges whose second sampling edge finds the block resting or waking are discarded and never delivered later. This includes the edge on which the wake-up window completes, and a low level held across the end of wake-up.
- R9: When a shutdown request and a conversion-start falling edge are sampled on the same edge in the ready state, the shutdown is taken and no `cnv_go` is produced.
- R10: `status_oh` is one-hot: bit 0 ready, bit 1 shallow rest, bit 2 deep rest, bit 3 waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown request level |
| depth_shallow | input | 1 | Rest depth select: 1 shallow, 0 deep |
| cnv_start_n | input | 1 | Active-low conversion-start strobe |
| logic_en | output | 1 | Digital logic domain enable |
| ref_en | output | 1 | Reference domain enable |
| bias_en | output | 1 | Analog bias domain enable |
| ready | output | 1 | High when conversions may start |
| cnv_go | output | 1 | One-cycle accepted conversion start |
| status_oh | output | 4 | One-hot state report |

## Verification
Two pairs of events can land on one clock edge: a conversion-start edge with the last edge of a wake-up window, and a conversion-start edge with a shutdown request. For both rest depths, the bench places the strobe's falling edge on every cycle position from the start of waking to two cycles past ready. It expects a pulse only when the edge is sampled after the state has become ready. For the other pair it lowers the request and the strobe together while the block is ready, and expects a rest state with no pulse.

// File: rtl/cps_pkg.sv
package cps_pkg;

   typedef enum logic [1:0] {
      PS_READY  = 2'd0,
      PS_NAP    = 2'd1,
      PS_DEEP   = 2'd2,
      PS_WAKING = 2'd3
   } pwr_state_t;

   localparam int unsigned NUM_STATES  = 4;
   localparam int unsigned NUM_DOMAINS = 3;
   localparam int unsigned DOM_LOGIC   = 0;
   localparam int unsigned DOM_REF     = 1;
   localparam int unsigned DOM_BIAS    = 2;

   // domain power policy per state
   function automatic logic domain_on(input int unsigned dom, input pwr_state_t st);
      logic on;
      case (st)
         PS_READY, PS_WAKING: on = 1'b1;
         PS_NAP:              on = (dom != DOM_BIAS);
         default:             on = 1'b0;
      endcase
      return on;
   endfunction

endpackage

// File: rtl/cps_wake_timer.sv
module cps_wake_timer #(
   parameter int unsigned NAP_CYC   = 50,
   parameter int unsigned SLEEP_CYC = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic deep,
   output logic done
);
   localparam int unsigned MAXC = (SLEEP_CYC > NAP_CYC) ? SLEEP_CYC : NAP_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] NAP_LD   = CW'(NAP_CYC - 1);
   localparam logic [CW-1:0] SLEEP_LD = CW'(SLEEP_CYC - 1);

   logic [CW-1:0] cnt_q;

   // reset loads the deep window so the first wake-up covers reference settling
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= SLEEP_LD;
      else if (load)            cnt_q <= deep ? SLEEP_LD : NAP_LD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
   import cps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shdn_n,
   input  logic       depth_shallow,
   input  logic       wake_done,
   output logic       load_wake,
   output logic       load_deep,
   output pwr_state_t state
);
   pwr_state_t state_q, state_d;
   pwr_state_t rest_pick;

   assign rest_pick = depth_shallow ? PS_NAP : PS_DEEP;

   always_comb begin
      state_d   = state_q;
      load_wake = 1'b0;
      load_deep = 1'b0;
      case (state_q)
         PS_READY: begin
            if (!shdn_n) state_d = rest_pick;
         end
         PS_NAP: begin
            if (shdn_n) begin
               state_d   = PS_WAKING;
               load_wake = 1'b1;
            end
         end
         PS_DEEP: begin
            if (shdn_n) begin
               state_d   = PS_WAKING;
               load_wake = 1'b1;
               load_deep = 1'b1;
            end
         end
         default: begin
            if (!shdn_n)        state_d = rest_pick;
            else if (wake_done) state_d = PS_READY;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_WAKING;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/cps_strobe_gate.sv
module cps_strobe_gate
   import cps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnv_start_n,
   input  logic       shdn_n,
   input  pwr_state_t state,
   output logic       cnv_go
);
   logic prev_q;
   logic go_q;
   logic fall;
   logic accept;

   assign fall   = prev_q & ~cnv_start_n;
   // a pending shutdown outranks a simultaneous strobe
   assign accept = (state == PS_READY) & shdn_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         go_q   <= 1'b0;
      end else begin
         prev_q <= cnv_start_n;
         go_q   <= fall & accept;
      end
   end

   assign cnv_go = go_q;
endmodule

// File: rtl/cps_domain_dec.sv
module cps_domain_dec
   import cps_pkg::*;
(
   input  pwr_state_t              state,
   output logic [NUM_DOMAINS-1:0]  dom_en,
   output logic [NUM_STATES-1:0]   status_oh
);
   for (genvar gd = 0; gd < NUM_DOMAINS; gd++) begin : g_dom
      assign dom_en[gd] = domain_on(gd, state);
   end

   for (genvar gs = 0; gs < NUM_STATES; gs++) begin : g_stat
      assign status_oh[gs] = (2'(state) == 2'(gs));
   end
endmodule

// File: rtl/conv_power_seq.sv
module conv_power_seq
   import cps_pkg::*;
#(
   parameter int unsigned NAP_WAKE_CYC   = 50,
   parameter int unsigned SLEEP_WAKE_CYC = 2500000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shdn_n,
   input  logic       depth_shallow,
   input  logic       cnv_start_n,
   output logic       logic_en,
   output logic       ref_en,
   output logic       bias_en,
   output logic       ready,
   output logic       cnv_go,
   output logic [3:0] status_oh
);
   if (NAP_WAKE_CYC < 1) begin : g_bad_nap
      $error("NAP_WAKE_CYC must be at least 1");
   end
   if (SLEEP_WAKE_CYC < NAP_WAKE_CYC) begin : g_bad_sleep
      $error("SLEEP_WAKE_CYC must not be shorter than NAP_WAKE_CYC");
   end

   pwr_state_t             state;
   logic                   wake_done;
   logic                   load_wake;
   logic                   load_deep;
   logic [NUM_DOMAINS-1:0] dom_en;
   logic [NUM_STATES-1:0]  stat;

   cps_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .shdn_n        (shdn_n),
      .depth_shallow (depth_shallow),
      .wake_done     (wake_done),
      .load_wake     (load_wake),
      .load_deep     (load_deep),
      .state         (state)
   );

   cps_wake_timer #(
      .NAP_CYC   (NAP_WAKE_CYC),
      .SLEEP_CYC (SLEEP_WAKE_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_wake),
      .deep  (load_deep),
      .done  (wake_done)
   );

   cps_strobe_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnv_start_n (cnv_start_n),
      .shdn_n      (shdn_n),
      .state       (state),
      .cnv_go      (cnv_go)
   );

   cps_domain_dec u_dec (
      .state     (state),
      .dom_en    (dom_en),
      .status_oh (stat)
   );

   assign logic_en  = dom_en[DOM_LOGIC];
   assign ref_en    = dom_en[DOM_REF];
   assign bias_en   = dom_en[DOM_BIAS];
   assign ready     = (state == PS_READY);
   assign status_oh = stat;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int unsigned NAP_WAKE_CYC   = 50,
   parameter int unsigned SLEEP_WAKE_CYC = 2500000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       shdn_n,
   input logic       cnv_start_n,
   input logic       logic_en,
   input logic       ref_en,
   input logic       bias_en,
   input logic       ready,
   input logic       cnv_go,
   input logic [3:0] status_oh
);
   localparam int unsigned MAXC = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1) + 1;

   logic [CW-1:0] wake_len;
   logic          was_deep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_len <= '0;
         was_deep <= 1'b1;
      end else begin
         wake_len <= status_oh[3] ? wake_len + 1'b1 : '0;
         if (status_oh[2])      was_deep <= 1'b1;
         else if (status_oh[1]) was_deep <= 1'b0;
      end
   end

   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_oh) == 1);

   a_r3_nap_domains: assert property (@(posedge clk) disable iff (!rst_n)
      status_oh[1] |-> (logic_en && ref_en && !bias_en));

   a_r3_deep_domains: assert property (@(posedge clk) disable iff (!rst_n)
      status_oh[2] |-> (!logic_en && !ref_en && !bias_en));

   a_r3_awake_domains: assert property (@(posedge clk) disable iff (!rst_n)
      (status_oh[0] || status_oh[3]) |-> (logic_en && ref_en && bias_en));

   a_r5_ready_only_active: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> status_oh[0]);

   a_r4_no_depth_swap_nap: assert property (@(posedge clk) disable iff (!rst_n)
      status_oh[1] |=> !status_oh[2]);

   a_r4_no_depth_swap_deep: assert property (@(posedge clk) disable iff (!rst_n)
      status_oh[2] |=> !status_oh[1]);

   a_r5_wake_length: assert property (@(posedge clk) disable iff (!rst_n)
      (status_oh[0] && $past(status_oh[3])) |->
         (wake_len == (was_deep ? CW'(SLEEP_WAKE_CYC) : CW'(NAP_WAKE_CYC))));

   a_r8_go_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_go |-> ($past(status_oh[0]) && $past(shdn_n) && !$past(cnv_start_n)));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_go |=> !cnv_go);

   a_r9_shutdown_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (status_oh[0] && !shdn_n) |=> !cnv_go);
endmodule

bind conv_power_seq cps_checker #(
   .NAP_WAKE_CYC   (NAP_WAKE_CYC),
   .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shdn_n      (shdn_n),
   .cnv_start_n (cnv_start_n),
   .logic_en    (logic_en),
   .ref_en      (ref_en),
   .bias_en     (bias_en),
   .ready       (ready),
   .cnv_go      (cnv_go),
   .status_oh   (status_oh)
);

// File: tb/sim_conv_power_seq.sv
module sim_conv_power_seq;
   localparam int NAPC = 5;
   localparam int SLPC = 23;
   localparam logic [3:0] ST_RDY = 4'b0001;
   localparam logic [3:0] ST_NAP = 4'b0010;
   localparam logic [3:0] ST_DEP = 4'b0100;
   localparam logic [3:0] ST_WAK = 4'b1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shdn_n = 1'b1;
   logic depth_shallow = 1'b1;
   logic cnv_start_n = 1'b1;
   logic logic_en, ref_en, bias_en, ready, cnv_go;
   logic [3:0] status_oh;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   conv_power_seq #(.NAP_WAKE_CYC(NAPC), .SLEEP_WAKE_CYC(SLPC)) u0 (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .depth_shallow(depth_shallow),
      .cnv_start_n(cnv_start_n), .logic_en(logic_en), .ref_en(ref_en),
      .bias_en(bias_en), .ready(ready), .cnv_go(cnv_go), .status_oh(status_oh)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // expected observation: {status, ready, logic, ref, bias, go}
   function automatic logic [8:0] expect_obs(input logic [3:0] st, input logic go);
      logic [2:0] en;
      case (st)
         ST_NAP:  en = 3'b110;
         ST_DEP:  en = 3'b000;
         default: en = 3'b111;
      endcase
      return {st, (st == ST_RDY), en, go};
   endfunction

   task automatic check(input string req, input logic [3:0] st, input logic go);
      logic [8:0] act, exp;
      act = {status_oh, ready, logic_en, ref_en, bias_en, cnv_go};
      exp = expect_obs(st, go);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic enter_rest(input logic shallow, input string req);
      depth_shallow = shallow;
      shdn_n = 1'b0;
      step();
      check(req, shallow ? ST_NAP : ST_DEP, 1'b0);
   endtask

   // wake with a strobe edge sampled on wake step k (0: none)
   task automatic wake_probe(input logic deep, input int k);
      int n;
      n = deep ? SLPC : NAPC;
      shdn_n = 1'b1;
      step();
      check("R5 enter waking", ST_WAK, 1'b0);
      for (int i = 2; i <= n + 3; i++) begin
         cnv_start_n = (i == k) ? 1'b0 : 1'b1;
         step();
         // R8: an edge accepted only if the state was ready before the edge
         check((k >= n + 2) ? "R7 strobe accepted" : "R8 strobe near wake",
               (i >= n + 1) ? ST_RDY : ST_WAK, (i == k) && (k >= n + 2));
      end
      cnv_start_n = 1'b1;
      step();
      check("R7 idle after pulse", ST_RDY, 1'b0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      check("R1 R10 reset state", ST_WAK, 1'b0);
      rst_n = 1'b1;
      for (int i = 1; i <= SLPC; i++) begin
         step();
         check("R1 post-reset wake", (i >= SLPC) ? ST_RDY : ST_WAK, 1'b0);
      end

      // sweep strobe position over both wake windows
      for (int d = 0; d < 2; d++) begin
         int n;
         n = (d == 1) ? SLPC : NAPC;
         for (int k = 0; k <= n + 3; k++) begin
            if (k == 1) continue;
            enter_rest(d == 0, "R2 rest entry");
            // R4: flip depth while resting, state and enables unchanged
            depth_shallow = ~depth_shallow;
            step();
            check("R4 depth change ignored", (d == 0) ? ST_NAP : ST_DEP, 1'b0);
            cnv_start_n = 1'b0;
            step();
            check("R8 strobe while resting", (d == 0) ? ST_NAP : ST_DEP, 1'b0);
            cnv_start_n = 1'b1;
            step();
            check("R8 no late pulse", (d == 0) ? ST_NAP : ST_DEP, 1'b0);
            wake_probe(d == 1, k);
         end
      end

      // R9: shutdown and strobe on the same edge
      cnv_start_n = 1'b0;
      depth_shallow = 1'b1;
      shdn_n = 1'b0;
      step();
      check("R9 shutdown beats strobe", ST_NAP, 1'b0);
      cnv_start_n = 1'b1;
      step();
      check("R9 no pulse after", ST_NAP, 1'b0);
      wake_probe(1'b0, 0);

      // R6: abort a deep wake, re-rest shallow, then nap-length wake
      enter_rest(1'b0, "R2 deep entry");
      shdn_n = 1'b1;
      step();
      check("R5 waking", ST_WAK, 1'b0);
      step(); step();
      check("R5 still waking", ST_WAK, 1'b0);
      depth_shallow = 1'b1;
      shdn_n = 1'b0;
      step();
      check("R6 abort to shallow", ST_NAP, 1'b0);
      wake_probe(1'b0, 0);

      // R8: low level held across end of wake gives no pulse
      enter_rest(1'b1, "R2 nap entry");
      shdn_n = 1'b1;
      step();
      cnv_start_n = 1'b0;
      for (int i = 2; i <= NAPC + 4; i++) begin
         step();
         check("R8 held low not queued", (i >= NAPC + 1) ? ST_RDY : ST_WAK, 1'b0);
      end
      cnv_start_n = 1'b1;
      step();
      check("R7 release", ST_RDY, 1'b0);

      // R7: back-to-back edges and a long low level
      for (int r = 0; r < 2; r++) begin
         cnv_start_n = 1'b0;
         step();
         check("R7 pulse", ST_RDY, 1'b1);
         cnv_start_n = 1'b1;
         step();
         check("R7 pulse ends", ST_RDY, 1'b0);
      end
      cnv_start_n = 1'b0;
      step();
      check("R7 long low first", ST_RDY, 1'b1);
      for (int i = 0; i < 3; i++) begin
         step();
         check("R7 long low single", ST_RDY, 1'b0);
      end
      cnv_start_n = 1'b1;
      step();
      check("R7 final idle", ST_RDY, 1'b0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule